// File: doc/BRIEF.md
# Nonzero Pivot Search and Row Address Sequencer

This block drives the row address of a matrix memory while a Gauss-Jordan elimination runs over a prime modulus. The arithmetic units and the matrix store sit elsewhere. The block watches every row write and looks at the value going into the first column. In each elimination step it picks one acceptable pivot from those values, so no separate search pass over the memory is needed. It then records the row of that pivot in a pivot-index vector at the slot of the current step, and it flags that row so later steps skip it.

A reduction pass is started once a step has closed. The pass emits row addresses on consecutive cycles: the pivot row of the latest found pivot comes first, then every other row in ascending order with the pivot row left out. The pass address latches the pivot at its start, so the search for the next step can run during the pass while updated rows are written back. When elimination is over, a readout pass emits the pivot rows in step order, which puts the solution column into unknown order. A step that closes without a pivot marks the matrix singular for this modulus.

Top module: `pivot_row_sequencer`

## Requirements
- R1: After reset, and on the cycle after a matrix start, singular_o is 0, all row flags are clear and the step count is 0. A matrix start also latches dim_i as the runtime size n, where 1 <= n <= MAX_N. Until a pass is started after reset, row_valid_o and pass_done_o stay 0.
- R2: A write whose row is below n is taken as the pivot of the current step only if its first-column value is nonzero, its row is not flagged, and no pivot has yet been taken in this step. Zero values and every later candidate in the same step have no effect.
- R3: Taking a pivot flags its row. A flagged row is never taken again as a pivot until the next matrix start, whatever value is later written to it.
- R4: A step end that closes a step with no pivot taken sets singular_o to 1. It stays 1 until the next matrix start, and the step count still advances.
- R5: A reduction pass starts with a pulse on red_start_i. On the next cycle row_valid_o is 1 and row_addr_o is the row of the most recently taken pivot. Over the next n-1 cycles, row_valid_o stays 1 and row_addr_o steps through the other rows below n in ascending order, never repeating the pivot row.
- R6: pass_done_o is a one-cycle pulse. It comes on the cycle after the last valid address of a pass, and row_valid_o is 0 in that cycle.
- R7: A readout pass starts with a pulse on read_start_i. On the n consecutive cycles after the start, row_addr_o gives the row recorded at steps 0, 1, ..., n-1 of the pivot-index vector, with row_valid_o at 1.
- R8: A start pulse of either kind has no effect while a pass is running. When both kinds are pulsed in the same idle cycle, the reduction pass is taken.
- R9: After n step ends, further step ends have no effect: singular_o does not change and no pivot is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mat_start_i | input | 1 | Start a new matrix: clear the flags, the step count and singular, and latch dim_i |
| dim_i | input | CNT_W | Runtime matrix size n |
| wr_valid_i | input | 1 | Row write strobe |
| wr_row_i | input | ROW_W | Index of the row being written |
| wr_val_i | input | VAL_W | First-column value of the row being written |
| step_end_i | input | 1 | Close the current elimination step |
| red_start_i | input | 1 | Start a reduction pass |
| read_start_i | input | 1 | Start a readout pass |
| row_addr_o | output | ROW_W | Generated row address |
| row_valid_o | output | 1 | row_addr_o is valid |
| pass_done_o | output | 1 | One-cycle pulse after the last address of a pass |
| singular_o | output | 1 | Sticky flag: some step closed without a pivot |

## Verification
Some properties are checked on every cycle. Every valid address stays below n, and inside a reduction pass the pivot row never shows up after the first address. The done pulse lasts one cycle and follows a valid address. A newly taken pivot always comes from a nonzero write and adds exactly one flagged row. Singular stays set until a matrix start, and the step count never goes past n. What a property cannot show is the exact address order, which row wins when several candidates compete, and the reordered readout. The bench scenarios cover these against a model of the acceptance rules: random matrices of varied size with many zero values, rows written twice or out of order, singular cases, extra step ends, and start pulses sent during a running pass.

// File: rtl/pivot_seq_pkg.sv
package pivot_seq_pkg;
  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_RED  = 2'd1,
    W_OUT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/pivot_search.sv
module pivot_search #(
  parameter int MAX_N = 16,
  parameter int VAL_W = 8,
  parameter int ROW_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mat_start_i,
  input  logic [CNT_W-1:0] dim_i,
  input  logic             wr_valid_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [VAL_W-1:0] wr_val_i,
  input  logic             step_end_i,
  input  logic [ROW_W-1:0] rd_idx_i,
  output logic [ROW_W-1:0] rd_row_o,
  output logic [ROW_W-1:0] pivot_o,
  output logic [CNT_W-1:0] dim_o,
  output logic             singular_o
);
  logic [MAX_N-1:0] flags_q;
  logic [ROW_W-1:0] vec_q [MAX_N];
  logic [CNT_W-1:0] step_q;
  logic [CNT_W-1:0] dim_q;
  logic [ROW_W-1:0] pivot_q;
  logic             found_q;
  logic             sing_q;
  logic [CNT_W-1:0] dim_clamp;
  logic             row_in_range;
  logic             step_open;
  logic             accept;

  always_comb begin
    dim_clamp = dim_i;
    if (dim_i > CNT_W'(MAX_N)) dim_clamp = CNT_W'(MAX_N);
    if (dim_i == '0)           dim_clamp = CNT_W'(1);
  end

  assign row_in_range = {{(CNT_W-ROW_W){1'b0}}, wr_row_i} < dim_q;
  assign step_open    = step_q < dim_q;
  // nonzero, unflagged, first in this step
  assign accept = wr_valid_i && (wr_val_i != '0) && row_in_range && step_open &&
                  !flags_q[wr_row_i] && !found_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      step_q  <= '0;
      dim_q   <= CNT_W'(1);
      pivot_q <= '0;
      found_q <= 1'b0;
      sing_q  <= 1'b0;
      for (int i = 0; i < MAX_N; i++) vec_q[i] <= '0;
    end else if (mat_start_i) begin
      flags_q <= '0;
      step_q  <= '0;
      dim_q   <= dim_clamp;
      found_q <= 1'b0;
      sing_q  <= 1'b0;
    end else begin
      if (accept) begin
        flags_q[wr_row_i]          <= 1'b1;
        vec_q[step_q[ROW_W-1:0]]   <= wr_row_i;
        pivot_q                    <= wr_row_i;
        found_q                    <= 1'b1;
      end
      if (step_end_i && step_open) begin
        step_q  <= step_q + CNT_W'(1);
        found_q <= 1'b0;
        if (!(found_q || accept)) sing_q <= 1'b1;
      end
    end
  end

  assign rd_row_o   = vec_q[rd_idx_i];
  assign pivot_o    = pivot_q;
  assign dim_o      = dim_q;
  assign singular_o = sing_q;

  // R2: a new pivot always comes from a nonzero write
  a_r2_pivot_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(found_q) |-> ($past(wr_valid_i) && ($past(wr_val_i) != '0)));

  // R3: a new pivot flags exactly one previously clear row
  a_r3_one_new_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(found_q) |-> ($countones(flags_q) == $countones($past(flags_q)) + 1));

  // R4: singular is sticky until a matrix start
  a_r4_sing_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sing_q && !mat_start_i) |=> sing_q);

  // R9: step count bounded by n
  a_r9_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= dim_q);
endmodule

// File: rtl/row_walker.sv
module row_walker
  import pivot_seq_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] dim_i,
  input  logic [ROW_W-1:0] pivot_i,
  input  logic             red_start_i,
  input  logic             out_start_i,
  input  logic [ROW_W-1:0] vec_row_i,
  output logic [ROW_W-1:0] vec_idx_o,
  output logic [ROW_W-1:0] row_addr_o,
  output logic             row_valid_o,
  output logic             pass_done_o
);
  localparam int NX_W = CNT_W + 1;

  walk_state_e      state_q;
  logic [ROW_W-1:0] piv_q;
  logic [NX_W-1:0]  next_q;
  logic [CNT_W-1:0] k_q;
  logic             first_q;
  logic [ROW_W-1:0] addr_q;
  logic             valid_q;
  logic             done_q;
  logic [NX_W-1:0]  piv_ext;
  logic [NX_W-1:0]  dim_ext;
  logic [NX_W-1:0]  nxt_one;
  logic [NX_W-1:0]  nxt_row;

  assign piv_ext = NX_W'(piv_q);
  assign dim_ext = NX_W'(dim_i);
  assign nxt_one = next_q + NX_W'(1);
  assign nxt_row = (nxt_one == piv_ext) ? next_q + NX_W'(2) : nxt_one;

  assign vec_idx_o = (state_q == W_OUT) ? k_q[ROW_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= W_IDLE;
      piv_q   <= '0;
      next_q  <= '0;
      k_q     <= '0;
      first_q <= 1'b0;
      addr_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      first_q <= 1'b0;
      case (state_q)
        W_IDLE: begin
          if (red_start_i) begin
            piv_q   <= pivot_i;
            addr_q  <= pivot_i;
            valid_q <= 1'b1;
            first_q <= 1'b1;
            next_q  <= (pivot_i == '0) ? NX_W'(1) : '0;
            state_q <= W_RED;
          end else if (out_start_i) begin
            addr_q  <= vec_row_i;
            valid_q <= 1'b1;
            k_q     <= CNT_W'(1);
            state_q <= W_OUT;
          end
        end
        W_RED: begin
          if (next_q < dim_ext) begin
            addr_q  <= next_q[ROW_W-1:0];
            valid_q <= 1'b1;
            next_q  <= nxt_row;
          end else begin
            done_q  <= 1'b1;
            state_q <= W_IDLE;
          end
        end
        W_OUT: begin
          if (k_q < dim_i) begin
            addr_q  <= vec_row_i;
            valid_q <= 1'b1;
            k_q     <= k_q + CNT_W'(1);
          end else begin
            done_q  <= 1'b1;
            state_q <= W_IDLE;
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign row_addr_o  = addr_q;
  assign row_valid_o = valid_q;
  assign pass_done_o = done_q;

  // R5: every address is a row of the matrix
  a_r5_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_valid_o |-> (CNT_W'(row_addr_o) < dim_i));

  // R5: the pivot row appears only first in a reduction pass
  a_r5_skip_pivot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_valid_o && (state_q == W_RED) && !first_q) |-> (row_addr_o != piv_q));

  // R6: done is a single pulse
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_done_o |=> !pass_done_o);

  // R6: done follows a valid address and is never with one
  a_r6_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_done_o |-> (!row_valid_o && $past(row_valid_o)));
endmodule

// File: rtl/pivot_row_sequencer.sv
module pivot_row_sequencer #(
  parameter int MAX_N = 16,
  parameter int VAL_W = 8,
  localparam int ROW_W = (MAX_N > 1) ? $clog2(MAX_N) : 1,
  localparam int CNT_W = $clog2(MAX_N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mat_start_i,
  input  logic [CNT_W-1:0] dim_i,
  input  logic             wr_valid_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [VAL_W-1:0] wr_val_i,
  input  logic             step_end_i,
  input  logic             red_start_i,
  input  logic             read_start_i,
  output logic [ROW_W-1:0] row_addr_o,
  output logic             row_valid_o,
  output logic             pass_done_o,
  output logic             singular_o
);
  logic [ROW_W-1:0] rd_idx;
  logic [ROW_W-1:0] rd_row;
  logic [ROW_W-1:0] pivot;
  logic [CNT_W-1:0] dim;

  pivot_search #(
    .MAX_N(MAX_N), .VAL_W(VAL_W), .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) u_search (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mat_start_i (mat_start_i),
    .dim_i       (dim_i),
    .wr_valid_i  (wr_valid_i),
    .wr_row_i    (wr_row_i),
    .wr_val_i    (wr_val_i),
    .step_end_i  (step_end_i),
    .rd_idx_i    (rd_idx),
    .rd_row_o    (rd_row),
    .pivot_o     (pivot),
    .dim_o       (dim),
    .singular_o  (singular_o)
  );

  row_walker #(
    .ROW_W(ROW_W), .CNT_W(CNT_W)
  ) u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dim_i       (dim),
    .pivot_i     (pivot),
    .red_start_i (red_start_i),
    .out_start_i (read_start_i),
    .vec_row_i   (rd_row),
    .vec_idx_o   (rd_idx),
    .row_addr_o  (row_addr_o),
    .row_valid_o (row_valid_o),
    .pass_done_o (pass_done_o)
  );
endmodule

// File: tb/pivot_row_sequencer_test.sv
module pivot_row_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_N = 16;
  localparam int VAL_W = 8;
  localparam int ROW_W = 4;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             mat_start_i = 1'b0;
  logic [CNT_W-1:0] dim_i = CNT_W'(1);
  logic             wr_valid_i = 1'b0;
  logic [ROW_W-1:0] wr_row_i = '0;
  logic [VAL_W-1:0] wr_val_i = '0;
  logic             step_end_i = 1'b0;
  logic             red_start_i = 1'b0;
  logic             read_start_i = 1'b0;
  logic [ROW_W-1:0] row_addr_o;
  logic             row_valid_o;
  logic             pass_done_o;
  logic             singular_o;

  int total = 0;
  int bad = 0;

  // model state
  bit m_flag [MAX_N];
  int m_vec  [MAX_N];
  int m_n, m_step, m_piv;
  bit m_found, m_sing;

  always #(CLK_PERIOD/2) clk = ~clk;

  pivot_row_sequencer #(.MAX_N(MAX_N), .VAL_W(VAL_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mat_start_i(mat_start_i), .dim_i(dim_i),
    .wr_valid_i(wr_valid_i), .wr_row_i(wr_row_i), .wr_val_i(wr_val_i),
    .step_end_i(step_end_i), .red_start_i(red_start_i), .read_start_i(read_start_i),
    .row_addr_o(row_addr_o), .row_valid_o(row_valid_o), .pass_done_o(pass_done_o),
    .singular_o(singular_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mat_start(input int n);
    mat_start_i = 1'b1;
    dim_i = CNT_W'(n);
    @(negedge clk);
    mat_start_i = 1'b0;
    m_n = n; m_step = 0; m_found = 0; m_sing = 0;
    for (int i = 0; i < MAX_N; i++) m_flag[i] = 0;
    check(singular_o == 1'b0, "R1 singular after start", singular_o, 0);
  endtask

  task automatic write_row(input int row, input int val);
    wr_valid_i = 1'b1;
    wr_row_i = ROW_W'(row);
    wr_val_i = VAL_W'(val);
    @(negedge clk);
    wr_valid_i = 1'b0;
    if (val != 0 && row < m_n && m_step < m_n && !m_flag[row] && !m_found) begin
      m_found = 1; m_piv = row; m_flag[row] = 1; m_vec[m_step] = row;
    end
  endtask

  task automatic step_end(input string req);
    step_end_i = 1'b1;
    @(negedge clk);
    step_end_i = 1'b0;
    if (m_step < m_n) begin
      if (!m_found) m_sing = 1;
      m_found = 0;
      m_step++;
    end
    check(singular_o == m_sing, req, singular_o, m_sing);
  endtask

  // kind 0: reduction, 1: readout; glitch sends extra starts mid-pass
  task automatic run_pass(input bit kind, input bit glitch);
    int exp_row [MAX_N];
    int j;
    if (kind == 0) begin
      exp_row[0] = m_piv;
      j = 1;
      for (int r = 0; r < m_n; r++) if (r != m_piv) begin exp_row[j] = r; j++; end
    end else begin
      for (int r = 0; r < m_n; r++) exp_row[r] = m_vec[r];
    end
    if (kind == 0) red_start_i = 1'b1; else read_start_i = 1'b1;
    @(negedge clk);
    red_start_i = 1'b0; read_start_i = 1'b0;
    for (int i = 0; i < m_n; i++) begin
      check(row_valid_o == 1'b1, kind ? "R7 valid" : "R5 valid", row_valid_o, 1);
      check(int'(row_addr_o) == exp_row[i], kind ? "R7 readout row" : "R5 reduction row",
            row_addr_o, exp_row[i]);
      if (glitch && i == 1) begin red_start_i = 1'b1; read_start_i = 1'b1; end
      @(negedge clk);
      red_start_i = 1'b0; read_start_i = 1'b0;
    end
    check(pass_done_o == 1'b1, glitch ? "R8 done after ignored start" : "R6 done pulse",
          pass_done_o, 1);
    check(row_valid_o == 1'b0, "R6 valid low at done", row_valid_o, 0);
    @(negedge clk);
    check(pass_done_o == 1'b0, "R6 done single", pass_done_o, 0);
    check(row_valid_o == 1'b0, "R8 no restart", row_valid_o, 0);
  endtask

  function automatic int rand_val();
    if ($urandom % 3 == 0) return 0;
    return int'($urandom % 255) + 1;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    check(singular_o == 1'b0, "R1 reset singular", singular_o, 0);
    check(row_valid_o == 1'b0, "R1 reset valid", row_valid_o, 0);
    check(pass_done_o == 1'b0, "R1 reset done", pass_done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // directed: zero rejected, first nonzero wins, later ignored
    mat_start(4);
    write_row(0, 0);
    write_row(1, 5);
    write_row(2, 7);
    step_end("R2 step close");
    check(m_piv == 1, "R2 model pivot", m_piv, 1);
    run_pass(0, 0);
    // flagged row 1 rejected, row 3 taken
    write_row(1, 9);
    write_row(3, 2);
    step_end("R3 step close");
    run_pass(0, 1);
    write_row(0, 4);
    step_end("R3 step close");
    run_pass(0, 0);
    write_row(2, 1);
    step_end("R3 step close");
    run_pass(0, 0);
    run_pass(1, 0);
    // R9: extra step ends without writes leave singular clear
    step_end("R9 extra step end");
    write_row(0, 3);
    step_end("R9 extra step end");
    run_pass(1, 1);

    // singular case, then clear by start
    mat_start(3);
    write_row(0, 0);
    write_row(1, 0);
    write_row(2, 0);
    step_end("R4 singular set");
    write_row(2, 6);
    step_end("R4 singular sticky");
    mat_start(3);
    write_row(2, 6);
    step_end("R1 cleared by start");

    // boundary n=1
    mat_start(1);
    write_row(0, 8);
    step_end("R2 n=1 step");
    run_pass(0, 0);
    run_pass(1, 0);

    // random matrices
    for (int t = 0; t < 40; t++) begin
      int n;
      n = (t == 0) ? MAX_N : int'($urandom % MAX_N) + 1;
      mat_start(n);
      for (int s = 0; s < n; s++) begin
        int w;
        w = n + int'($urandom % 3);
        for (int q = 0; q < w; q++) write_row(int'($urandom % n), rand_val());
        step_end(m_sing ? "R4 random singular" : "R2 random step");
        if (!m_sing) run_pass(0, ($urandom % 5) == 0);
      end
      if (!m_sing) run_pass(1, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule